// File: doc/BRIEF.md
# Shared Interrupt Priority Vector Unit

This block funnels a set of event sources into one interrupt request line. It has a main group of sixteen sources and an auxiliary group of four, and each source has its own pending latch. A one-cycle pulse on a source input sets that latch. The latch is set whether or not the source is enabled, so software can always poll for activity.

Each group has an enable register. A source drives the shared request only when it is pending, its enable bit is set, and the global enable input is high. A read-only vector register names the most urgent source that is both pending and enabled. Reading the vector also clears that source's latch. A handler can therefore read the vector repeatedly to work through all outstanding sources, without doing any explicit clearing writes.

Some sources carry ordinary event pulses. Others carry overrun pulses from an upstream capture stage whose buffer was already full. The unit treats both kinds the same way.

Top module: `irq_prio_vec`

## Requirements
- R1: After a synchronous reset, every register reads zero and `irq` is low. The registers are both enable registers, both pending registers and the vector.
- R2: A pulse on `evt_main[k]` or `evt_aux[j]` sets the matching pending bit at the next clock edge, whatever the enable bits hold. Main pending reads at address 1 as bits k. Auxiliary pending reads at address 3 as bits j (3:0), and bits 15:4 read zero.
- R3: The main enable register sits at address 0 and takes all 16 bits of a write. The auxiliary enable register sits at address 2 and keeps only write bits 3:0. Its reserved bits 15:4 read zero and ignore written data.
- R4: `irq` is registered. In the cycle after an edge, it equals the global enable `irq_en` ANDed with "any source pending and enabled", both sampled at that edge.
- R5: A read at address 4 returns the vector. It is 0 when no source is both pending and enabled. Otherwise it is k+1 for main source k or 17+j for auxiliary source j, and the lowest value present wins. The global enable does not affect the vector.
- R6: A vector read that returns a nonzero value clears exactly that source's pending bit, at the same edge. All other pending bits are unchanged.
- R7: If a source's event pulse arrives in the same cycle as the vector read that would clear it, the pulse wins and the bit stays pending.
- R8: Writes to addresses 1, 3, 4 and any unused address change no state.
- R9: `reg_rdata` is registered. It shows the addressed value in the cycle after a read cycle and zero after any cycle without a read. Addresses 5 to 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_main | input | 16 | Event pulses, main source group |
| evt_aux | input | 4 | Event pulses, auxiliary source group |
| irq_en | input | 1 | Global enable of the shared request |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| irq | output | 1 | Shared interrupt request |

## Verification
Random stimulus uses sparse event pulses together with frequent vector reads and enable rewrites. This keeps several sources pending at once with partial enables, which tests the priority order and separates the pending state from the enabled state. Directed cases cover four situations:
- a vector read with nothing enabled;
- a set and a clear colliding on the same source;
- writes aimed at read-only addresses;
- a toggled global enable.

Each directed case isolates one behaviour that random traffic rarely hits cleanly.

// File: rtl/ipv_pkg.sv
package ipv_pkg;
  localparam int SEL_W = 3;
  localparam logic [SEL_W-1:0] SEL_MMASK = 3'd0;
  localparam logic [SEL_W-1:0] SEL_MPEND = 3'd1;
  localparam logic [SEL_W-1:0] SEL_AMASK = 3'd2;
  localparam logic [SEL_W-1:0] SEL_APEND = 3'd3;
  localparam logic [SEL_W-1:0] SEL_VEC   = 3'd4;
endpackage

// File: rtl/ipv_pending.sv
module ipv_pending #(
  parameter int N = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)           pend_o[g] <= 1'b0;
      else if (set_i[g]) pend_o[g] <= 1'b1;   // set has priority over clear
      else if (clr_i[g]) pend_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/ipv_prio.sv
module ipv_prio #(
  parameter int N  = 20,
  parameter int VW = 5
) (
  input  logic [N-1:0]  req_i,
  output logic [VW-1:0] vec_o,
  output logic [N-1:0]  hit_o
);
  // Scan from the top down so the lowest index is the last to overwrite.
  always_comb begin
    vec_o = '0;
    hit_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        vec_o    = VW'(i + 1);
        hit_o    = '0;
        hit_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ipv_regif.sv
module ipv_regif
  import ipv_pkg::*;
#(
  parameter int MAIN_N = 16,
  parameter int AUX_N  = 4,
  parameter int DATA_W = 16,
  parameter int VW     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [SEL_W-1:0]  addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [MAIN_N-1:0] main_pend_i,
  input  logic [AUX_N-1:0]  aux_pend_i,
  input  logic [VW-1:0]     vec_i,
  output logic [MAIN_N-1:0] main_mask_o,
  output logic [AUX_N-1:0]  aux_mask_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] rmux;

  always_ff @(posedge clk) begin
    if (rst) begin
      main_mask_o <= '0;
      aux_mask_o  <= '0;
    end else if (wr_i) begin
      if (addr_i == SEL_MMASK) main_mask_o <= wdata_i[MAIN_N-1:0];
      if (addr_i == SEL_AMASK) aux_mask_o  <= wdata_i[AUX_N-1:0];
    end
  end

  always_comb begin
    case (addr_i)
      SEL_MMASK: rmux = DATA_W'(main_mask_o);
      SEL_MPEND: rmux = DATA_W'(main_pend_i);
      SEL_AMASK: rmux = DATA_W'(aux_mask_o);
      SEL_APEND: rmux = DATA_W'(aux_pend_i);
      SEL_VEC:   rmux = DATA_W'(vec_i);
      default:   rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata_o <= '0;
    else if (rd_i) rdata_o <= rmux;
    else           rdata_o <= '0;
  end
endmodule

// File: rtl/irq_prio_vec.sv
module irq_prio_vec
  import ipv_pkg::*;
#(
  parameter int MAIN_N = 16,
  parameter int AUX_N  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MAIN_N-1:0] evt_main,
  input  logic [AUX_N-1:0]  evt_aux,
  input  logic              irq_en,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [SEL_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int SRC_N = MAIN_N + AUX_N;
  localparam int VW    = $clog2(SRC_N + 1);

  logic [SRC_N-1:0]  pend_all, mask_all, req_all, hit_all, clr_all;
  logic [MAIN_N-1:0] main_mask;
  logic [AUX_N-1:0]  aux_mask;
  logic [VW-1:0]     vec;
  logic              vec_rd;

  assign mask_all = {aux_mask, main_mask};
  assign req_all  = pend_all & mask_all;
  assign vec_rd   = reg_rd && (reg_addr == SEL_VEC);
  assign clr_all  = vec_rd ? hit_all : '0;

  ipv_pending #(.N(SRC_N)) u_pend (
    .clk(clk), .rst(rst),
    .set_i({evt_aux, evt_main}),
    .clr_i(clr_all),
    .pend_o(pend_all)
  );

  ipv_prio #(.N(SRC_N), .VW(VW)) u_prio (
    .req_i(req_all), .vec_o(vec), .hit_o(hit_all)
  );

  ipv_regif #(.MAIN_N(MAIN_N), .AUX_N(AUX_N), .DATA_W(DATA_W), .VW(VW)) u_regs (
    .clk(clk), .rst(rst),
    .rd_i(reg_rd), .wr_i(reg_wr), .addr_i(reg_addr), .wdata_i(reg_wdata),
    .main_pend_i(pend_all[MAIN_N-1:0]),
    .aux_pend_i(pend_all[SRC_N-1:MAIN_N]),
    .vec_i(vec),
    .main_mask_o(main_mask), .aux_mask_o(aux_mask),
    .rdata_o(reg_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= irq_en & (|req_all);
  end
endmodule

// File: rtl/irq_prio_vec_chk.sv
module irq_prio_vec_chk #(
  parameter int SRC_N  = 20,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [SRC_N-1:0]  evt_all,
  input logic [SRC_N-1:0]  pend_all,
  input logic [SRC_N-1:0]  mask_all,
  input logic              irq_en,
  input logic              vec_rd,
  input logic              reg_rd,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              irq
);
  // R2: an event leaves its pending bit set at the next edge
  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (rst)
    (|evt_all) |=> ((pend_all & $past(evt_all)) == $past(evt_all)));

  // R4: request needs the global enable and an enabled pending source
  assert_irq_gated_R4: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(irq_en) && (|($past(pend_all) & $past(mask_all)))));

  // R6: pending bits only fall after a vector read, and one at most
  assert_clear_by_read_R6: assert property (@(posedge clk) disable iff (rst)
    (|($past(pend_all) & ~pend_all)) |-> $past(vec_rd));

  assert_clear_single_R6: assert property (@(posedge clk) disable iff (rst)
    $countones($past(pend_all) & ~pend_all) <= 1);

  // R9: no read, no data
  assert_idle_rdata_R9: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> (reg_rdata == '0));
endmodule

bind irq_prio_vec irq_prio_vec_chk #(.SRC_N(SRC_N), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .evt_all({evt_aux, evt_main}),
  .pend_all(pend_all), .mask_all(mask_all), .irq_en(irq_en),
  .vec_rd(vec_rd), .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq(irq)
);

// File: tb/sim_irq_prio_vec.sv
`timescale 1ns/1ps
module sim_irq_prio_vec;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] evt_main;
  logic [3:0]  evt_aux;
  logic        irq_en, reg_rd, reg_wr;
  logic [2:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic        irq;

  int checks = 0, fails = 0;
  logic [19:0] m_pend = '0, m_mask = '0;
  logic [15:0] exp_rd;
  logic        exp_irq;

  always #2 clk = ~clk;

  irq_prio_vec u0 (.clk(clk), .rst(rst), .evt_main(evt_main), .evt_aux(evt_aux),
    .irq_en(irq_en), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  function automatic logic [4:0] vec_of(logic [19:0] p, logic [19:0] m);
    for (int i = 0; i < 20; i++) if (p[i] & m[i]) return 5'(i + 1);
    return 5'd0;
  endfunction

  function automatic logic [15:0] read_of(logic [2:0] a);
    case (a)
      3'd0: return m_mask[15:0];
      3'd1: return m_pend[15:0];
      3'd2: return {12'd0, m_mask[19:16]};
      3'd3: return {12'd0, m_pend[19:16]};
      3'd4: return {11'd0, vec_of(m_pend, m_mask)};
      default: return 16'd0;
    endcase
  endfunction

  function automatic string tag_of(logic rd, logic [2:0] a);
    if (!rd) return "R9";
    case (a)
      3'd0, 3'd2: return "R3";
      3'd1, 3'd3: return "R2";
      3'd4:       return "R5";
      default:    return "R9";
    endcase
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(logic [15:0] em, logic [3:0] ea, logic rd, logic wr,
                     logic [2:0] a, logic [15:0] wd, logic en, string tag);
    logic [4:0]  v;
    logic [19:0] clr;
    evt_main = em; evt_aux = ea; reg_rd = rd; reg_wr = wr;
    reg_addr = a; reg_wdata = wd; irq_en = en;
    @(posedge clk);
    exp_rd  = rd ? read_of(a) : 16'd0;
    exp_irq = en & (|(m_pend & m_mask));
    v   = vec_of(m_pend, m_mask);
    clr = '0;
    if (rd && a == 3'd4 && v != 0) clr[v-1] = 1'b1;
    if (wr && a == 3'd0) m_mask[15:0]  = wd;
    if (wr && a == 3'd2) m_mask[19:16] = wd[3:0];
    m_pend = (m_pend & ~clr) | {ea, em};
    @(negedge clk);
    check((tag == "") ? tag_of(rd, a) : tag, reg_rdata, exp_rd);
    check("R4", {15'd0, irq}, {15'd0, exp_irq});
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    rst = 1'b1; evt_main = '0; evt_aux = '0; irq_en = 1'b0;
    reg_rd = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1: reset state of every register and the request
    check("R1", {15'd0, irq}, 16'd0);
    for (int a = 0; a < 5; a++) cyc('0, '0, 1'b1, 1'b0, 3'(a), '0, 1'b1, "R1");
    // R3: reserved auxiliary enable bits ignore written ones
    cyc('0, '0, 1'b0, 1'b1, 3'd2, 16'hFFF5, 1'b1, "R3");
    cyc('0, '0, 1'b1, 1'b0, 3'd2, '0, 1'b1, "R3");
    // R2 / R5: masked event pends but vector stays 0
    cyc(16'h0008, '0, 1'b0, 1'b0, 3'd0, '0, 1'b1, "R2");
    cyc('0, '0, 1'b1, 1'b0, 3'd4, '0, 1'b1, "R5");
    cyc('0, '0, 1'b1, 1'b0, 3'd1, '0, 1'b1, "R2");
    // R8: writes to read-only addresses change nothing
    cyc('0, '0, 1'b0, 1'b1, 3'd1, 16'h0000, 1'b1, "R8");
    cyc('0, '0, 1'b0, 1'b1, 3'd4, 16'hFFFF, 1'b1, "R8");
    cyc('0, '0, 1'b0, 1'b1, 3'd6, 16'hFFFF, 1'b1, "R8");
    cyc('0, '0, 1'b1, 1'b0, 3'd1, '0, 1'b1, "R8");
    cyc('0, '0, 1'b1, 1'b0, 3'd0, '0, 1'b1, "R8");
    // R7: enable source 3, then collide event with the clearing read
    cyc('0, '0, 1'b0, 1'b1, 3'd0, 16'h0008, 1'b0, "R3");
    cyc(16'h0008, '0, 1'b1, 1'b0, 3'd4, '0, 1'b0, "R7");
    cyc('0, '0, 1'b1, 1'b0, 3'd1, '0, 1'b1, "R7");
    // R6: a plain read now clears it; aux source 2 pending with priority below
    cyc('0, 4'b0100, 1'b1, 1'b0, 3'd4, '0, 1'b1, "R6");
    cyc('0, '0, 1'b1, 1'b0, 3'd1, '0, 1'b1, "R6");
    cyc('0, '0, 1'b1, 1'b0, 3'd3, '0, 1'b1, "R6");
    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] em;
      logic [3:0]  ea;
      int          op;
      em = ($urandom % 4 == 0) ? 16'(1 << ($urandom % 16)) : '0;
      ea = ($urandom % 8 == 0) ? 4'(1 << ($urandom % 4)) : '0;
      op = $urandom % 10;
      if (op < 4)      cyc(em, ea, 1'b1, 1'b0, 3'd4, '0, ($urandom % 4) != 0, "");
      else if (op < 6) cyc(em, ea, 1'b0, 1'b1, 3'(($urandom % 2) * 2),
                           16'($urandom), ($urandom % 4) != 0, "");
      else if (op < 9) cyc(em, ea, 1'b1, ($urandom % 4) == 0, 3'($urandom % 8),
                           16'($urandom), ($urandom % 4) != 0, "");
      else             cyc(em, ea, 1'b0, 1'b0, 3'd0, '0, ($urandom % 4) != 0, "");
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule